// File: doc/BRIEF.md
# Task-Event Timer Counter

A register-mapped timer/counter with four capture/compare channels. Software controls it through a word-addressed write/read bus. Writing a word whose bit 0 is set to one of the task addresses triggers an action: start, stop, count, clear, shut down, or capture into channel n. Each compare channel owns an event flag. The flag is set by hardware when the counter steps onto the channel's compare value, and software clears it by writing zero to it.

The counter advances in one of two ways. In timer mode it advances from a power-of-two division of the clock. In counter mode it advances once per count task. Four counter widths can be selected, and their codes are not in increasing order. A compare match can zero the counter or halt it through per-channel shortcut bits. Matches are also reported as one-cycle pulses and, through per-channel enables, as one level-sensitive interrupt.

Top module: `evtimer_top`

## Requirements
- R1: After reset the counter is zero and stopped. The mode, width, prescaler, shortcut, interrupt-enable, compare and event registers all read zero, and irq and cmp_pulse are low.
- R2: A write with wdata bit 0 set to 0x000 starts, 0x004 stops, 0x008 counts, 0x00C clears, 0x010 shuts down, and 0x040+4n captures channel n. A write to a task address with bit 0 clear has no effect.
- R3: In timer mode (0x504 bit 0 = 0), a running counter advances once every 2^P clock cycles, where P is bits 3:0 of 0x510. START restarts the division.
- R4: In counter mode (0x504 bit 0 = 1), the counter advances only on a count task and only while running. A stopped counter holds its value.
- R5: Bits 1:0 of 0x508 select the width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. Each increment result is masked to that width, and compare values are masked the same way before comparison.
- R6: When an increment produces the value of compare register n, the event at 0x140+4n reads 1 from the next cycle, and cmp_pulse[n] is high for exactly that one cycle.
- R7: Writing 0 to an event register clears it. Writing any nonzero value leaves it unchanged.
- R8: The shortcut register at 0x200 keeps only the bits under mask 0xF0F. Bit n zeroes the counter in place of the matching value, and bit 8+n stops the counter on a channel n match.
- R9: Interrupt enables for channel n sit at bit 16+n. Writing 0x304 sets the written ones, writing 0x308 clears them, and either address reads the enables back. irq is high while any event with its enable set is 1.
- R10: A capture task copies the current counter into compare register n at 0x540+4n, and that register is also software-writable.
- R11: CLEAR zeroes the counter and leaves the running state unchanged. SHUTDOWN stops the counter and zeroes it.
- R12: A CLEAR in the same cycle as a timer tick leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for addr/wdata |
| addr | input | 12 | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Enabled-event interrupt level |
| cmp_pulse | output | 4 | One-cycle compare match pulse per channel |

## Verification
The bench uses the default build: four channels, a 32-bit data path and a 4-bit prescaler field. With these values a 24-bit run past 65535, and then a switch to 16-bit, shows both that the wider width does not wrap early and that the narrower width masks the next increment. The 8-bit width wraps within a few hundred cycles, so compare values above 255 can be shown to match through masking. Prescaler codes up to 3 are randomised. Wrap-around at 24 and 32 bits is out of reach in the cycle budget.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  localparam int CH_N     = 4;
  localparam int DW       = 32;
  localparam int AW       = 12;
  localparam int PSC_W    = 4;
  localparam int STOP_LSB = 8;
  localparam int IEN_LSB  = 16;

  localparam logic [AW-1:0] A_START   = 12'h000;
  localparam logic [AW-1:0] A_STOP    = 12'h004;
  localparam logic [AW-1:0] A_COUNT   = 12'h008;
  localparam logic [AW-1:0] A_CLEAR   = 12'h00C;
  localparam logic [AW-1:0] A_SHUT    = 12'h010;
  localparam logic [AW-1:0] A_CAP0    = 12'h040;
  localparam logic [AW-1:0] A_EVT0    = 12'h140;
  localparam logic [AW-1:0] A_SHORT   = 12'h200;
  localparam logic [AW-1:0] A_IEN_SET = 12'h304;
  localparam logic [AW-1:0] A_IEN_CLR = 12'h308;
  localparam logic [AW-1:0] A_MODE    = 12'h504;
  localparam logic [AW-1:0] A_WIDTH   = 12'h508;
  localparam logic [AW-1:0] A_PSC     = 12'h510;
  localparam logic [AW-1:0] A_CC0     = 12'h540;

  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_8  = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } width_e;

  typedef struct packed {
    logic            start;
    logic            stop;
    logic            count;
    logic            clear;
    logic            shutdown;
    logic [CH_N-1:0] capture;
    logic [CH_N-1:0] evt_clr;
  } strobe_t;

  function automatic logic [DW-1:0] width_mask(input width_e w);
    case (w)
      WID_8:   width_mask = DW'(32'h0000_00FF);
      WID_16:  width_mask = DW'(32'h0000_FFFF);
      WID_24:  width_mask = DW'(32'h00FF_FFFF);
      default: width_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/evtimer_regs.sv
module evtimer_regs
  import evtimer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic [DW-1:0]             cnt,
  input  logic [CH_N-1:0]           evt,
  output strobe_t                   stb,
  output logic                      mode,
  output width_e                    width,
  output logic [PSC_W-1:0]          psc,
  output logic [CH_N-1:0]           clr_short,
  output logic [CH_N-1:0]           stop_short,
  output logic [CH_N-1:0]           inten,
  output logic [CH_N-1:0][DW-1:0]   cc,
  output logic [DW-1:0]             rdata
);
  logic                    go;
  logic                    mode_d;
  width_e                  width_d;
  logic [PSC_W-1:0]        psc_d;
  logic [CH_N-1:0]         clr_d, stop_d, ien_d;
  logic [CH_N-1:0][DW-1:0] cc_d;

  assign go = wr_en & wdata[0];

  // task and event-clear strobes
  always_comb begin
    stb          = '0;
    stb.start    = go && (addr == A_START);
    stb.stop     = go && (addr == A_STOP);
    stb.count    = go && (addr == A_COUNT);
    stb.clear    = go && (addr == A_CLEAR);
    stb.shutdown = go && (addr == A_SHUT);
    for (int n = 0; n < CH_N; n++) begin
      stb.capture[n] = go && (addr == A_CAP0 + AW'(4*n));
      stb.evt_clr[n] = wr_en && (wdata == '0) && (addr == A_EVT0 + AW'(4*n));
    end
  end

  // configuration next state
  always_comb begin
    mode_d  = mode;
    width_d = width;
    psc_d   = psc;
    clr_d   = clr_short;
    stop_d  = stop_short;
    ien_d   = inten;
    cc_d    = cc;
    if (wr_en) begin
      if (addr == A_MODE)    mode_d  = wdata[0];
      if (addr == A_WIDTH)   width_d = width_e'(wdata[1:0]);
      if (addr == A_PSC)     psc_d   = wdata[PSC_W-1:0];
      if (addr == A_SHORT) begin
        clr_d  = wdata[CH_N-1:0];
        stop_d = wdata[STOP_LSB +: CH_N];
      end
      if (addr == A_IEN_SET) ien_d = inten | wdata[IEN_LSB +: CH_N];
      if (addr == A_IEN_CLR) ien_d = inten & ~wdata[IEN_LSB +: CH_N];
      for (int n = 0; n < CH_N; n++)
        if (addr == A_CC0 + AW'(4*n)) cc_d[n] = wdata;
    end
    for (int n = 0; n < CH_N; n++)
      if (stb.capture[n]) cc_d[n] = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= 1'b0;
      width      <= WID_16;
      psc        <= '0;
      clr_short  <= '0;
      stop_short <= '0;
      inten      <= '0;
      cc         <= '0;
    end else if (wr_en) begin
      mode       <= mode_d;
      width      <= width_d;
      psc        <= psc_d;
      clr_short  <= clr_d;
      stop_short <= stop_d;
      inten      <= ien_d;
      cc         <= cc_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == A_SHORT) begin
      rdata[CH_N-1:0]           = clr_short;
      rdata[STOP_LSB +: CH_N]   = stop_short;
    end
    if (addr == A_IEN_SET || addr == A_IEN_CLR) rdata[IEN_LSB +: CH_N] = inten;
    if (addr == A_MODE)  rdata[0]         = mode;
    if (addr == A_WIDTH) rdata[1:0]       = width;
    if (addr == A_PSC)   rdata[PSC_W-1:0] = psc;
    for (int n = 0; n < CH_N; n++) begin
      if (addr == A_EVT0 + AW'(4*n)) rdata[0] = evt[n];
      if (addr == A_CC0 + AW'(4*n))  rdata    = cc[n];
    end
  end
endmodule

// File: rtl/evtimer_prescale.sv
module evtimer_prescale
  import evtimer_pkg::*;
#(
  parameter int DIV_W = 1 << PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d, lim;

  always_comb begin
    lim   = (DIV_W'(1) << psc) - DIV_W'(1);
    tick  = en & (div_q == lim);
    div_d = div_q;
    if (restart)  div_d = '0;
    else if (en)  div_d = tick ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div_q <= '0;
    else if (restart || en)   div_q <= div_d;
  end
endmodule

// File: rtl/evtimer_core.sv
module evtimer_core
  import evtimer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 stb,
  input  logic                    mode,
  input  width_e                  width,
  input  logic                    tick,
  input  logic [CH_N-1:0]         clr_short,
  input  logic [CH_N-1:0]         stop_short,
  input  logic [CH_N-1:0][DW-1:0] cc,
  output logic                    run,
  output logic [DW-1:0]           cnt,
  output logic [CH_N-1:0]         evt,
  output logic [CH_N-1:0]         pulse,
  output logic                    adv,
  output logic                    zero_req
);
  logic [DW-1:0]   wmask, step, cnt_d;
  logic [CH_N-1:0] hit, evt_d;
  logic            run_d;

  assign zero_req = stb.clear | stb.shutdown;
  assign wmask    = width_mask(width);
  assign adv      = run & ~zero_req & (mode ? stb.count : tick);
  assign step     = (cnt + DW'(1)) & wmask;

  for (genvar n = 0; n < CH_N; n++) begin : g_cmp
    assign hit[n] = adv & (step == (cc[n] & wmask));
  end

  always_comb begin
    cnt_d = cnt;
    if (zero_req)  cnt_d = '0;
    else if (adv)  cnt_d = (|(hit & clr_short)) ? '0 : step;
    run_d = run;
    if (stb.start) run_d = 1'b1;
    if (stb.stop || stb.shutdown || (|(hit & stop_short))) run_d = 1'b0;
    evt_d = (evt & ~stb.evt_clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run   <= 1'b0;
      evt   <= '0;
      pulse <= '0;
    end else begin
      if (zero_req || adv) cnt <= cnt_d;
      run   <= run_d;
      evt   <= evt_d;
      pulse <= hit;
    end
  end
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq,
  output logic [CH_N-1:0] cmp_pulse
);
  logic [1:0]              rsync_q;
  logic                    rst_ns;
  strobe_t                 stb;
  logic                    mode, tick, run, adv, zero_req;
  width_e                  width;
  logic [PSC_W-1:0]        psc;
  logic [CH_N-1:0]         clr_short, stop_short, inten, evt;
  logic [CH_N-1:0][DW-1:0] cc;
  logic [DW-1:0]           cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  evtimer_regs u_regs (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .evt(evt), .stb(stb), .mode(mode), .width(width), .psc(psc),
    .clr_short(clr_short), .stop_short(stop_short), .inten(inten), .cc(cc),
    .rdata(rdata)
  );

  evtimer_prescale u_psc (
    .clk(clk), .rst_n(rst_ns), .en(run & ~mode),
    .restart(stb.start | stb.clear | stb.shutdown), .psc(psc), .tick(tick)
  );

  evtimer_core u_core (
    .clk(clk), .rst_n(rst_ns), .stb(stb), .mode(mode), .width(width), .tick(tick),
    .clr_short(clr_short), .stop_short(stop_short), .cc(cc), .run(run), .cnt(cnt),
    .evt(evt), .pulse(cmp_pulse), .adv(adv), .zero_req(zero_req)
  );

  assign irq = |(evt & inten);
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk
  import evtimer_pkg::*;
(
  input logic            clk,
  input logic            rst_ns,
  input logic            run,
  input logic            adv,
  input logic            zero_req,
  input width_e          width,
  input logic [DW-1:0]   cnt,
  input logic [CH_N-1:0] evt,
  input logic [CH_N-1:0] pulse,
  input logic [CH_N-1:0] stop_short,
  input logic            irq
);
  assert_w8_bound_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (adv && width == WID_8) |=> (cnt[DW-1:8] == '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (!run && !zero_req) |=> $stable(cnt));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    irq |-> (|evt));

  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rst_ns)
      pulse[n] |-> evt[n]);

    assert_stop_short_R8: assert property (@(posedge clk) disable iff (!rst_ns)
      (pulse[n] && $past(stop_short[n])) |-> !run);
  end
endmodule

bind evtimer_top evtimer_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .run(run), .adv(adv), .zero_req(zero_req),
  .width(width), .cnt(cnt), .evt(evt), .pulse(cmp_pulse),
  .stop_short(stop_short), .irq(irq)
);

// File: tb/tb_evtimer_top.sv
module tb_evtimer_top;
  localparam logic [11:0] T_START = 12'h000, T_STOP = 12'h004, T_COUNT = 12'h008;
  localparam logic [11:0] T_CLEAR = 12'h00C, T_SHUT = 12'h010, T_CAP = 12'h040;
  localparam logic [11:0] R_EVT = 12'h140, R_SHORT = 12'h200, R_ISET = 12'h304;
  localparam logic [11:0] R_ICLR = 12'h308, R_MODE = 12'h504, R_WID = 12'h508;
  localparam logic [11:0] R_PSC = 12'h510, R_CC = 12'h540;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  cmp_pulse;

  always #2.5 clk = ~clk;

  evtimer_top dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0]      mdl_cnt;
  logic [3:0]       mdl_evt;
  logic [3:0][31:0] cur_cc;
  logic [3:0]       cur_clr, cur_stop;
  logic [1:0]       cur_w;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input string what, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk); addr = a; #1 d = rdata;
    check(req, what, d, exp);
  endtask

  function automatic logic [31:0] wm(input logic [1:0] w);
    case (w)
      2'd0: wm = 32'h0000_FFFF;
      2'd1: wm = 32'h0000_00FF;
      2'd2: wm = 32'h00FF_FFFF;
      default: wm = 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic model(input int n);
    logic [31:0] c;
    logic        go, zap;
    c = '0; go = 1'b1; mdl_evt = '0;
    for (int i = 0; i < n; i++) begin
      if (go) begin
        c = (c + 1) & wm(cur_w);
        zap = 1'b0;
        for (int k = 0; k < 4; k++)
          if (c == (cur_cc[k] & wm(cur_w))) begin
            mdl_evt[k] = 1'b1;
            if (cur_clr[k])  zap = 1'b1;
            if (cur_stop[k]) go = 1'b0;
          end
        if (zap) c = '0;
      end
    end
    mdl_cnt = c;
  endtask

  task automatic setup(input logic m, input logic [1:0] w, input logic [3:0] p,
                       input logic [3:0] cl, input logic [3:0] st, input logic [3:0][31:0] ccv);
    wr(T_SHUT, 1);
    for (int k = 0; k < 4; k++) wr(R_EVT + 12'(4*k), 0);
    wr(R_MODE, {31'd0, m});
    wr(R_WID, {30'd0, w});
    wr(R_PSC, {28'd0, p});
    wr(R_SHORT, {20'd0, st, 4'd0, cl});
    for (int k = 0; k < 4; k++) wr(R_CC + 12'(4*k), ccv[k]);
    cur_w = w; cur_clr = cl; cur_stop = st; cur_cc = ccv;
  endtask

  task automatic run_timer(input int m);
    wr(T_START, 1);
    repeat (m) @(posedge clk);
    wr(T_STOP, 1);
  endtask

  task automatic cap_chk(input string req, input string what, input logic [31:0] exp);
    wr(T_CAP + 12'hC, 1);
    chk_rd(req, what, R_CC + 12'hC, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0][31:0] ccv;
    logic [31:0] ien;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check("R1", "irq", {31'd0, irq}, 0);
    check("R1", "cmp_pulse", {28'd0, cmp_pulse}, 0);
    chk_rd("R1", "mode", R_MODE, 0);
    chk_rd("R1", "width", R_WID, 0);
    chk_rd("R1", "prescaler", R_PSC, 0);
    chk_rd("R1", "shortcuts", R_SHORT, 0);
    chk_rd("R1", "inten", R_ISET, 0);
    chk_rd("R1", "cc1", R_CC + 12'h4, 0);
    chk_rd("R1", "event0", R_EVT, 0);
    cap_chk("R1", "counter zero", 0);

    // register masks
    wr(R_SHORT, 32'hFFFF_FFFF);
    chk_rd("R8", "shortcut mask", R_SHORT, 32'h0000_0F0F);
    wr(R_SHORT, 0);
    wr(R_ISET, 32'hFFFF_FFFF);
    chk_rd("R9", "inten set", R_ISET, 32'h000F_0000);
    wr(R_ICLR, 32'h0005_0000);
    chk_rd("R9", "inten clr readback", R_ICLR, 32'h000A_0000);
    wr(R_ICLR, 32'hFFFF_FFFF);
    wr(R_MODE, 32'hFF); chk_rd("R4", "mode bit", R_MODE, 1);
    wr(R_WID, 32'hFF);  chk_rd("R5", "width bits", R_WID, 3);
    wr(R_PSC, 32'hFF);  chk_rd("R3", "prescaler bits", R_PSC, 32'hF);

    // counter mode: ignored tasks, capture, pulse, events
    ccv = {32'h80, 32'h80, 32'h5, 32'h80};
    setup(1, 2'd1, 0, 0, 0, ccv);
    wr(T_START, 1);
    wr(T_COUNT, 2);
    repeat (3) wr(T_COUNT, 1);
    wr(T_CAP, 1);
    chk_rd("R2", "bit0-clear count ignored, capture ch0", R_CC, 3);
    wr(T_STOP, 1);
    wr(T_COUNT, 1);
    wr(T_CAP + 12'h8, 1);
    chk_rd("R4", "count while stopped, capture ch2", R_CC + 12'h8, 3);
    chk_rd("R10", "cc1 written value", R_CC + 12'h4, 5);
    wr(T_START, 1);
    wr(T_COUNT, 1);
    check("R6", "no pulse before match", {28'd0, cmp_pulse}, 0);
    wr(T_COUNT, 1);
    check("R6", "pulse on match", {28'd0, cmp_pulse}, 32'h2);
    @(posedge clk); #1;
    check("R6", "pulse one cycle", {28'd0, cmp_pulse}, 0);
    chk_rd("R6", "event1 set", R_EVT + 12'h4, 1);
    wr(R_EVT + 12'h4, 5);
    chk_rd("R7", "nonzero write ignored", R_EVT + 12'h4, 1);
    check("R9", "irq masked", {31'd0, irq}, 0);
    wr(R_ISET, 32'h0002_0000);
    check("R9", "irq enabled", {31'd0, irq}, 1);
    wr(R_ICLR, 32'h0002_0000);
    check("R9", "irq disabled", {31'd0, irq}, 0);
    wr(R_ISET, 32'h0002_0000);
    wr(R_EVT + 12'h4, 0);
    chk_rd("R7", "event cleared", R_EVT + 12'h4, 0);
    check("R9", "irq after clear", {31'd0, irq}, 0);
    wr(R_ICLR, 32'hFFFF_FFFF);

    // CLEAR keeps running, SHUTDOWN stops
    wr(T_CLEAR, 1);
    repeat (2) wr(T_COUNT, 1);
    cap_chk("R11", "clear keeps running", 2);
    wr(T_SHUT, 1);
    wr(T_COUNT, 1);
    cap_chk("R11", "shutdown stops and zeroes", 0);

    // CLEAR against a timer tick
    ccv = {4{32'hFFFF_FFFF}};
    setup(0, 2'd0, 0, 0, 0, ccv);
    wr(T_START, 1);
    repeat (3) @(posedge clk);
    wr(T_CLEAR, 1);
    wr(T_STOP, 1);
    cap_chk("R12", "clear wins over tick", 1);

    // prescaler
    setup(0, 2'd0, 4'd2, 0, 0, ccv);
    run_timer(19);
    cap_chk("R3", "prescale 4", 5);

    // 8-bit wrap with masked compare
    ccv = {4{32'h100}};
    setup(0, 2'd1, 0, 0, 0, ccv);
    run_timer(259);
    model(260);
    cap_chk("R5", "8-bit wrap", mdl_cnt);
    chk_rd("R5", "masked compare event2", R_EVT + 12'h8, {31'd0, mdl_evt[2]});

    // randomised runs
    for (int it = 0; it < 30; it++) begin
      logic m; logic [1:0] w; logic [3:0] p; int n;
      m = 1'($urandom % 2); w = 2'($urandom % 4); p = 4'($urandom % 4);
      for (int k = 0; k < 4; k++) ccv[k] = $urandom % 24;
      ien = $urandom;
      setup(m, w, p, 4'($urandom), 4'($urandom), ccv);
      wr(R_ICLR, 32'h000F_0000);
      wr(R_ISET, {12'd0, ien[3:0], 16'd0});
      if (m) begin
        n = $urandom % 40;
        wr(T_START, 1);
        for (int i = 0; i < n; i++) wr(T_COUNT, 1);
        wr(T_STOP, 1);
      end else begin
        int mm;
        mm = $urandom % 50;
        run_timer(mm);
        n = (mm + 1) >> p;
      end
      model(n);
      cap_chk(m ? "R4" : "R3", "random run count (R8 shortcuts)", mdl_cnt);
      for (int k = 0; k < 4; k++)
        chk_rd("R6", "random run event", R_EVT + 12'(4*k), {31'd0, mdl_evt[k]});
      check("R9", "random irq", {31'd0, irq}, {31'd0, |(mdl_evt & ien[3:0])});
    end

    // long 24-bit run, then narrow to 16 bits
    ccv = {4{32'hFFFF_FFFF}};
    setup(0, 2'd2, 0, 0, 0, ccv);
    run_timer(65538);
    cap_chk("R5", "24-bit passes 16-bit limit", 32'd65539);
    wr(R_WID, 0);
    wr(R_MODE, 1);
    wr(T_START, 1);
    wr(T_COUNT, 1);
    wr(T_STOP, 1);
    cap_chk("R5", "16-bit masks increment", 32'd4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule